// File: doc/BRIEF.md
# Slot-Linked Instruction Fetch Sequencer

This block produces the instruction fetch address for a processor core that has no incrementing program counter. A block register, which never counts by itself, selects a group of eight instruction words. Each instruction carries its own three-bit field that names the slot of the next instruction inside that group. The fetch address is the block register with the slot appended below it. Moving on to the next group is an ordinary register write: an ALU increment of the block value, placed in any slot of the group.

Decoded strobes from the instruction decoder steer the sequencer. A jump or call loads the block register from the immediate operand and takes the new slot from the instruction. A return restores the block register from the value popped off the return stack and takes the resumption slot from the return instruction. An add with embedded branch uses the carry flag to choose between two slot fields that both lie inside the current group. The sequencer also gives the return address that a call saves, and the word address of an in-line literal stored at block plus displacement. A hold input from the video system freezes the sequencer while another master owns the shared memory.

Top module: `slotlink_fetch_seq`

## Requirements
- R1: With no control strobe active and hold low, the next fetch address is the unchanged block register followed by the 3-bit `nxt_slot_i` value, so fetch address bits [2:0] equal the slot field of the previous cycle.
- R2: The block register (fetch address bits [18:3]) keeps its value on every edge where none of jump, call, return or block write is active.
- R3: A block write alone loads `alu_i` with bit 0 forced to 0 into the block register, and the slot comes from `nxt_slot_i`. Block-register bit 0 is never 1.
- R4: A jump loads `target_i` (bit 0 forced to 0) into the block register and `nxt_slot_i` into the slot.
- R5: `ret_addr_o` always equals the current block register, so in the cycle of a call it presents the block value to be saved. A call changes block and slot the same way a jump does.
- R6: A return loads `ret_blk_i` (bit 0 forced to 0) into the block register and `nxt_slot_i` into the slot.
- R7: An add with branch (`add_br_i`) leaves the block register unchanged and selects `alt_slot_i` when `carry_i XOR br_inv_i` is 1, and `nxt_slot_i` otherwise. `br_inv_i` = 0 gives branch on carry and 1 gives branch on no carry.
- R8: `lit_addr_o` equals {block register, 3'b000} plus the zero-extended 8-bit `disp_i`, modulo 2^19, and it follows the block register combinationally.
- R9: While `hold_i` is high, block register and slot do not change, whatever the strobes are.
- R10: After reset the fetch address and `ret_addr_o` are 0.
- R11: Priority is return, then call or jump (which share `target_i`), then block write. Any of return, call or jump overrides the add-branch slot choice and uses `nxt_slot_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_i | input | 1 | Freeze request from the shared-memory master |
| nxt_slot_i | input | 3 | Next-slot field of the current instruction |
| alt_slot_i | input | 3 | Branch-taken slot field of an add with branch |
| jump_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| add_br_i | input | 1 | Add with embedded branch strobe |
| br_inv_i | input | 1 | Branch polarity: 0 on carry, 1 on no carry |
| carry_i | input | 1 | Carry flag |
| blk_wr_i | input | 1 | Block-register write strobe |
| target_i | input | 16 | Immediate jump or call target block |
| ret_blk_i | input | 16 | Block value popped from the return stack |
| alu_i | input | 16 | ALU result for a block-register write |
| disp_i | input | 8 | Literal displacement from the block base |
| fetch_addr_o | output | 19 | Instruction fetch word address |
| ret_addr_o | output | 16 | Block value to save on a call |
| lit_addr_o | output | 19 | Word address of an in-line literal |

## Verification
The in-module assertions check on every cycle that the hold freeze applies to both registers, that bit 0 of the block register stays clear, that the block register stays put when nothing loads it, that a jump loads its target, and that an add-branch takes the slot chosen by the carry. The priority between colliding strobes, return-address timing around a call, literal-address wrap at the top of the space and the full slot, carry and polarity sweeps are shown only by the bench scenarios, which compare against addresses computed arithmetically.

// File: rtl/slotseq_pkg.sv
package slotseq_pkg;
   // Source of the next block-register value.
   typedef enum logic [1:0] {
      BSRC_KEEP   = 2'd0,
      BSRC_TARGET = 2'd1,
      BSRC_RETURN = 2'd2,
      BSRC_ALU    = 2'd3
   } blk_src_e;

   localparam int unsigned SLOTSEQ_BLK_W  = 16;
   localparam int unsigned SLOTSEQ_SLOT_W = 3;
   localparam int unsigned SLOTSEQ_DISP_W = 8;
endpackage

// File: rtl/slotseq_blk_reg.sv
module slotseq_blk_reg
   import slotseq_pkg::*;
#(
   parameter int unsigned BLK_W      = SLOTSEQ_BLK_W,
   parameter bit          FORCE_EVEN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             jump,
   input  logic             call,
   input  logic             ret,
   input  logic             wr,
   input  logic [BLK_W-1:0] target,
   input  logic [BLK_W-1:0] ret_blk,
   input  logic [BLK_W-1:0] alu,
   output logic [BLK_W-1:0] blk_q
);
   generate
      if (BLK_W < 2) begin : g_bad_w
         $error("slotseq_blk_reg: BLK_W must be at least 2");
      end
   endgenerate

   blk_src_e         src;
   logic [BLK_W-1:0] raw_d;
   logic [BLK_W-1:0] blk_d;

   always_comb begin
      if (ret)               src = BSRC_RETURN;
      else if (call || jump) src = BSRC_TARGET;
      else if (wr)           src = BSRC_ALU;
      else                   src = BSRC_KEEP;
   end

   always_comb begin
      unique case (src)
         BSRC_RETURN: raw_d = ret_blk;
         BSRC_TARGET: raw_d = target;
         BSRC_ALU:    raw_d = alu;
         default:     raw_d = blk_q;
      endcase
   end

   generate
      if (FORCE_EVEN) begin : g_even
         assign blk_d = raw_d & ~BLK_W'(1);
      end else begin : g_any
         assign blk_d = raw_d;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     blk_q <= '0;
      else if (!hold) blk_q <= blk_d;
   end

   AST_BLK_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !FORCE_EVEN || (blk_q[0] == 1'b0))
      else $error("block register bit 0 set"); // R3

   AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(blk_q))
      else $error("block register moved under hold"); // R9

   AST_BLK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!jump && !call && !ret && !wr) |=> $stable(blk_q))
      else $error("block register moved without a load"); // R2

   AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && jump && !ret) |=>
         (blk_q[BLK_W-1:1] == $past(target[BLK_W-1:1])))
      else $error("jump did not load target"); // R4
endmodule

// File: rtl/slotseq_slot_reg.sv
module slotseq_slot_reg
   import slotseq_pkg::*;
#(
   parameter int unsigned SLOT_W = SLOTSEQ_SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              xfer,
   input  logic              add_br,
   input  logic              br_inv,
   input  logic              carry,
   input  logic [SLOT_W-1:0] nxt_slot,
   input  logic [SLOT_W-1:0] alt_slot,
   output logic [SLOT_W-1:0] slot_q
);
   generate
      if (SLOT_W < 1) begin : g_bad_w
         $error("slotseq_slot_reg: SLOT_W must be at least 1");
      end
   endgenerate

   logic              taken;
   logic [SLOT_W-1:0] slot_d;

   assign taken  = add_br && !xfer && (carry ^ br_inv);
   assign slot_d = taken ? alt_slot : nxt_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q <= '0;
      else if (!hold) slot_q <= slot_d;
   end

   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(slot_q))
      else $error("slot moved under hold"); // R9

   AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && add_br && !xfer && (carry != br_inv)) |=> (slot_q == $past(alt_slot)))
      else $error("add-branch did not take alternate slot"); // R7

   AST_XFER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && xfer) |=> (slot_q == $past(nxt_slot)))
      else $error("transfer did not use next-slot field"); // R11
endmodule

// File: rtl/slotseq_lit_addr.sv
module slotseq_lit_addr
   import slotseq_pkg::*;
#(
   parameter int unsigned BLK_W  = SLOTSEQ_BLK_W,
   parameter int unsigned SLOT_W = SLOTSEQ_SLOT_W,
   parameter int unsigned DISP_W = SLOTSEQ_DISP_W
) (
   input  logic [BLK_W-1:0]        blk,
   input  logic [DISP_W-1:0]       disp,
   output logic [BLK_W+SLOT_W-1:0] lit_addr
);
   localparam int unsigned AW = BLK_W + SLOT_W;

   generate
      if (DISP_W > AW) begin : g_bad_w
         $error("slotseq_lit_addr: DISP_W wider than the address");
      end
   endgenerate

   assign lit_addr = {blk, {SLOT_W{1'b0}}} + AW'(disp);
endmodule

// File: rtl/slotlink_fetch_seq.sv
module slotlink_fetch_seq
   import slotseq_pkg::*;
#(
   parameter int unsigned BLK_W      = SLOTSEQ_BLK_W,
   parameter int unsigned SLOT_W     = SLOTSEQ_SLOT_W,
   parameter int unsigned DISP_W     = SLOTSEQ_DISP_W,
   parameter bit          FORCE_EVEN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     hold_i,
   input  logic [SLOT_W-1:0]        nxt_slot_i,
   input  logic [SLOT_W-1:0]        alt_slot_i,
   input  logic                     jump_i,
   input  logic                     call_i,
   input  logic                     ret_i,
   input  logic                     add_br_i,
   input  logic                     br_inv_i,
   input  logic                     carry_i,
   input  logic                     blk_wr_i,
   input  logic [BLK_W-1:0]         target_i,
   input  logic [BLK_W-1:0]         ret_blk_i,
   input  logic [BLK_W-1:0]         alu_i,
   input  logic [DISP_W-1:0]        disp_i,
   output logic [BLK_W+SLOT_W-1:0]  fetch_addr_o,
   output logic [BLK_W-1:0]         ret_addr_o,
   output logic [BLK_W+SLOT_W-1:0]  lit_addr_o
);
   localparam int unsigned AW = BLK_W + SLOT_W;

   logic [BLK_W-1:0]  blk_q;
   logic [SLOT_W-1:0] slot_q;
   logic              xfer;

   assign xfer = jump_i | call_i | ret_i;

   slotseq_blk_reg #(.BLK_W(BLK_W), .FORCE_EVEN(FORCE_EVEN)) u_blk (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (hold_i),
      .jump    (jump_i),
      .call    (call_i),
      .ret     (ret_i),
      .wr      (blk_wr_i),
      .target  (target_i),
      .ret_blk (ret_blk_i),
      .alu     (alu_i),
      .blk_q   (blk_q)
   );

   slotseq_slot_reg #(.SLOT_W(SLOT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold_i),
      .xfer     (xfer),
      .add_br   (add_br_i),
      .br_inv   (br_inv_i),
      .carry    (carry_i),
      .nxt_slot (nxt_slot_i),
      .alt_slot (alt_slot_i),
      .slot_q   (slot_q)
   );

   slotseq_lit_addr #(.BLK_W(BLK_W), .SLOT_W(SLOT_W), .DISP_W(DISP_W)) u_lit (
      .blk      (blk_q),
      .disp     (disp_i),
      .lit_addr (lit_addr_o)
   );

   assign fetch_addr_o = {blk_q, slot_q};
   assign ret_addr_o   = blk_q;

   AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (fetch_addr_o == AW'($past(fetch_addr_o))))
      else $error("fetch address moved under hold"); // R9

   AST_CALL_RET: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && call_i && !ret_i) |=> (ret_addr_o[BLK_W-1:1] == $past(target_i[BLK_W-1:1])))
      else $error("call did not load target block"); // R5
endmodule

// File: tb/slotlink_fetch_seq_tb.sv
module slotlink_fetch_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold_i = 1'b0;
   logic [2:0]  nxt_slot_i = '0;
   logic [2:0]  alt_slot_i = '0;
   logic        jump_i = 1'b0, call_i = 1'b0, ret_i = 1'b0;
   logic        add_br_i = 1'b0, br_inv_i = 1'b0, carry_i = 1'b0, blk_wr_i = 1'b0;
   logic [15:0] target_i = '0, ret_blk_i = '0, alu_i = '0;
   logic [7:0]  disp_i = '0;
   logic [18:0] fetch_addr_o, lit_addr_o;
   logic [15:0] ret_addr_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [15:0] eb;
   logic [2:0]  es;

   always #2 clk = ~clk;

   slotlink_fetch_seq u_dut (
      .clk(clk), .rst_n(rst_n), .hold_i(hold_i),
      .nxt_slot_i(nxt_slot_i), .alt_slot_i(alt_slot_i),
      .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i),
      .add_br_i(add_br_i), .br_inv_i(br_inv_i), .carry_i(carry_i),
      .blk_wr_i(blk_wr_i), .target_i(target_i), .ret_blk_i(ret_blk_i),
      .alu_i(alu_i), .disp_i(disp_i),
      .fetch_addr_o(fetch_addr_o), .ret_addr_o(ret_addr_o), .lit_addr_o(lit_addr_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      jump_i = 0; call_i = 0; ret_i = 0; add_br_i = 0; blk_wr_i = 0;
      hold_i = 0; br_inv_i = 0; carry_i = 0;
   endtask

   function automatic logic [31:0] fa(input logic [15:0] b, input logic [2:0] s);
      return {13'd0, b, s};
   endfunction

   initial begin
      #(4 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R10 fetch after reset", fetch_addr_o, 0);
      chk("R10 ret_addr after reset", ret_addr_o, 0);
      rst_n = 1'b1;
      eb = 0;

      // R1 / R2: plain slot sequencing, block register stays still
      for (int s = 0; s < 8; s++) begin
         nxt_slot_i = 3'(7 - s);
         alu_i = 16'(s * 16'h1357);
         target_i = 16'(s * 16'h0777);
         tick();
         chk("R1 slot follows field", fetch_addr_o, fa(eb, 3'(7 - s)));
         chk("R2 block unchanged", ret_addr_o, eb);
      end

      // R3: block write (odd values masked)
      for (int i = 0; i < 16; i++) begin
         alu_i = 16'(16'h1235 + i * 16'h0F0F);
         nxt_slot_i = 3'(i);
         blk_wr_i = 1;
         tick();
         eb = alu_i & 16'hFFFE;
         chk("R3 block write", fetch_addr_o, fa(eb, 3'(i)));
         blk_wr_i = 0;
         nxt_slot_i = 3'(i + 3);
         tick();
         chk("R2 block held after write", fetch_addr_o, fa(eb, 3'(i + 3)));
      end

      // R4: jump sweep
      for (int t = 0; t < 32; t++) begin
         target_i = 16'(t * 16'h0841 + 1);
         alu_i = 16'hDEAD;
         nxt_slot_i = 3'(t);
         jump_i = 1;
         tick();
         eb = target_i & 16'hFFFE;
         chk("R4 jump", fetch_addr_o, fa(eb, 3'(t)));
      end
      jump_i = 0;

      // R5: call saves current block
      target_i = 16'h4A20; nxt_slot_i = 3'd5; jump_i = 1;
      tick();
      jump_i = 0;
      target_i = 16'h1003; nxt_slot_i = 3'd3; call_i = 1;
      #1;
      chk("R5 ret_addr in call cycle", ret_addr_o, 16'h4A20);
      tick();
      call_i = 0;
      chk("R5 call target", fetch_addr_o, fa(16'h1002, 3'd3));
      chk("R5 ret_addr tracks block", ret_addr_o, 16'h1002);

      // R6: return sweep
      for (int s = 0; s < 8; s++) begin
         ret_blk_i = 16'(16'h4A21 + s * 16'h2222);
         nxt_slot_i = 3'(s);
         ret_i = 1;
         tick();
         eb = ret_blk_i & 16'hFFFE;
         chk("R6 return", fetch_addr_o, fa(eb, 3'(s)));
      end
      ret_i = 0;

      // R7: add-branch over carry, polarity, slot
      for (int c = 0; c < 2; c++)
         for (int v = 0; v < 2; v++)
            for (int a = 0; a < 8; a++) begin
               add_br_i = 1; carry_i = c[0]; br_inv_i = v[0];
               alt_slot_i = 3'(a); nxt_slot_i = 3'(a) ^ 3'b101;
               tick();
               es = (c[0] ^ v[0]) ? 3'(a) : (3'(a) ^ 3'b101);
               chk("R7 add-branch slot", fetch_addr_o, fa(eb, es));
            end
      idle();

      // R8: literal address, normal block then wrap at the top
      for (int d = 0; d < 256; d++) begin
         disp_i = 8'(d);
         #1;
         chk("R8 literal address", lit_addr_o, 32'(19'({eb, 3'b000} + 19'(d))));
      end
      target_i = 16'hFFFF; nxt_slot_i = 0; jump_i = 1;
      tick();
      jump_i = 0;
      eb = 16'hFFFE;
      for (int d = 0; d < 256; d += 5) begin
         disp_i = 8'(d);
         #1;
         chk("R8 literal wrap", lit_addr_o, 32'(19'({eb, 3'b000} + 19'(d))));
      end

      // R9: hold freezes everything
      nxt_slot_i = 3'd6;
      tick();
      es = 3'd6;
      for (int k = 0; k < 8; k++) begin
         hold_i = 1;
         jump_i = k[0]; ret_i = k[1]; blk_wr_i = 1; add_br_i = 1; carry_i = 1;
         target_i = 16'h0100; ret_blk_i = 16'h0200; alu_i = 16'h0300;
         nxt_slot_i = 3'(k); alt_slot_i = 3'(k + 1);
         tick();
         chk("R9 hold freeze", fetch_addr_o, fa(eb, es));
      end
      idle();

      // R11: priorities
      target_i = 16'h2468; alu_i = 16'h1111; nxt_slot_i = 3'd1;
      jump_i = 1; blk_wr_i = 1;
      tick();
      chk("R11 jump over write", fetch_addr_o, fa(16'h2468, 3'd1));
      idle();
      target_i = 16'h3579; alu_i = 16'h2222; nxt_slot_i = 3'd2;
      call_i = 1; blk_wr_i = 1;
      tick();
      chk("R11 call over write", fetch_addr_o, fa(16'h3578, 3'd2));
      idle();
      ret_blk_i = 16'h7770; target_i = 16'h0AA0; nxt_slot_i = 3'd4;
      ret_i = 1; jump_i = 1;
      tick();
      chk("R11 return over jump", fetch_addr_o, fa(16'h7770, 3'd4));
      idle();
      ret_blk_i = 16'h5550; nxt_slot_i = 3'd0; alt_slot_i = 3'd7;
      ret_i = 1; add_br_i = 1; carry_i = 1;
      tick();
      chk("R11 return overrides add-branch", fetch_addr_o, fa(16'h5550, 3'd0));
      idle();

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule